// File: doc/BRIEF.md
# Slow-Clock System Timer

This peripheral keeps time from a slow reference tick. The tick arrives as a one-cycle enable, `tickEn`, in the host clock domain. A prescaler divides the tick into increments of a wrapping real-time counter. An alarm register holds an absolute counter value and flags the moment the counter arrives at it. A separate interval divider flags every N ticks, which gives a periodic heartbeat.

The sources collect in a status register that clears when read. The interrupt mask is changed only through two write-only ports: one sets mask bits, the other clears them. The single interrupt line is high while any pending status bit is also enabled in the mask.

Software uses the alarm as a one-shot by writing the current count plus a delta of at least one increment. It uses the interval divider as a periodic tick. A read at the count address gives a timestamp.

Top module: `slow_timer`

## Requirements
- R1: After reset, the registers read as follows: count 0, scale 32768, alarm 0, period 0, status 0 and mask 0. `irq` is low.
- R2: The counter advances by one each time `scale` ticks of `tickEn` have elapsed, so a scale of 1 advances it on every tick. A scale of 0 means 65536 ticks. Writing the scale restarts the prescale count, and a tick in the cycle of that write is not counted.
- R3: The counter is COUNT_W bits wide (20 by default) and wraps from its maximum value to 0.
- R4: Status bit 3 (alarm) sets only when an increment makes the counter equal to the alarm register. If the alarm is written with the value the counter already holds, it does not fire until the counter has gone all the way round.
- R5: Status bit 0 (interval) sets each time `period` ticks have elapsed. A period of 0 means 65536 ticks. Writing the period restarts the interval count, and a tick in the cycle of that write is not counted.
- R6: Status bit 2 (increment) sets on every counter increment. Status bit 1 (watchdog) always reads 0.
- R7: A read of the status address returns the pending bits and clears them. A bit whose event occurs in the same cycle as that read stays set.
- R8: Writing to the enable address sets the mask bits that are 1 in `wrData[3:0]`. Writing to the disable address clears them. Zero bits leave the mask unchanged. The mask reads back at its own address.
- R9: `irq` is high exactly when some status bit is set and its mask bit is also set.
- R10: Register map by `addr`:
  - 0: period (read/write)
  - 1: scale (read/write)
  - 2: alarm (read/write)
  - 3: status (read-clear)
  - 4: enable (write-only)
  - 5: disable (write-only)
  - 6: mask (read)
  - 7: count (read)

  `rdData` is driven combinationally while `rdEn` is high. Otherwise, and for any other address, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle strobe per slow-clock period |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe; a read of status clears it |
| rdData | output | DATA_W | Read data, valid in the cycle of `rdEn` |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports.

The first is the alarm armed at the counter's current value, which must stay silent for a full wrap. The bench builds the timer with a 12-bit counter and a scale of 1. It then writes the alarm in a cycle with no tick and runs 4095 and then one more increment, so the wrap completes in about four thousand cycles.

The second is a status read that lands on the same edge as a new event. The bench reads status on every cycle while ticks arrive on every cycle, so the set-and-clear collision happens repeatedly. A behavioural model is checked against the bench on each cycle.

// File: rtl/slow_timer_pkg.sv
package slow_timer_pkg;
  // register addresses
  localparam int ADR_PERIOD = 0;
  localparam int ADR_SCALE  = 1;
  localparam int ADR_ALARM  = 2;
  localparam int ADR_STATUS = 3;
  localparam int ADR_IEN    = 4;
  localparam int ADR_IDIS   = 5;
  localparam int ADR_MASK   = 6;
  localparam int ADR_COUNT  = 7;

  // status bit positions
  localparam int ST_IV   = 0;
  localparam int ST_WDOG = 1;
  localparam int ST_INC  = 2;
  localparam int ST_ALM  = 3;
  localparam int NUM_SRC = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic wrPeriod;
    logic wrScale;
    logic wrAlarm;
  } strobe_t;

  // datapath -> control events
  typedef struct packed {
    logic iv;
    logic inc;
    logic alm;
  } evt_t;
endpackage

// File: rtl/slow_timer_div.sv
// Tick divider: raises hit on the tick that completes `limit` ticks.
// A limit of 0 stands for 2**W. A load restarts the count and wins over a tick.
module slow_timer_div #(
  parameter int W         = 16,
  parameter int RST_LIMIT = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         tick,
  output logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic [W:0]   limEff;
  logic         atEnd;

  assign limEff = (limit == '0) ? {1'b1, {W{1'b0}}} : {1'b0, limit};
  assign atEnd  = ({1'b0, cnt} == (limEff - 1'b1));
  assign hit    = tick & atEnd & ~load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      limit <= W'(RST_LIMIT);
    end else if (load) begin
      cnt   <= '0;
      limit <= loadVal;
    end else if (tick) begin
      cnt <= atEnd ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/slow_timer_dp.sv
module slow_timer_dp
  import slow_timer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int COUNT_W   = 20,
  parameter int SCALE_W   = 16,
  parameter int PERIOD_W  = 16,
  parameter int SCALE_RST = 32768
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [COUNT_W-1:0]  count,
  output logic [COUNT_W-1:0]  alarmVal,
  output logic [SCALE_W-1:0]  scaleVal,
  output logic [PERIOD_W-1:0] periodVal,
  output evt_t                evt
);
  localparam int USED_A = (COUNT_W > SCALE_W) ? COUNT_W : SCALE_W;
  localparam int USED_W = (USED_A > PERIOD_W) ? USED_A : PERIOD_W;

  logic               incEvt;
  logic [COUNT_W-1:0] nextCount;

  slow_timer_div #(.W(SCALE_W), .RST_LIMIT(SCALE_RST)) u_presc (
    .clk(clk), .rstN(rstN), .load(stb.wrScale), .loadVal(wrData[SCALE_W-1:0]),
    .tick(tickEn), .limit(scaleVal), .hit(incEvt)
  );

  slow_timer_div #(.W(PERIOD_W), .RST_LIMIT(0)) u_interval (
    .clk(clk), .rstN(rstN), .load(stb.wrPeriod), .loadVal(wrData[PERIOD_W-1:0]),
    .tick(tickEn), .limit(periodVal), .hit(evt.iv)
  );

  assign nextCount = count + 1'b1;
  assign evt.inc   = incEvt;
  assign evt.alm   = incEvt & (nextCount == alarmVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      alarmVal <= '0;
    end else begin
      if (incEvt)      count    <= nextCount;
      if (stb.wrAlarm) alarmVal <= wrData[COUNT_W-1:0];
    end
  end

  generate
    if (USED_W < DATA_W) begin : g_spare
      logic unusedHi;
      assign unusedHi = ^wrData[DATA_W-1:USED_W];
    end
  endgenerate
endmodule

// File: rtl/slow_timer_ctrl.sv
module slow_timer_ctrl
  import slow_timer_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int COUNT_W  = 20,
  parameter int SCALE_W  = 16,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  input  evt_t                evt,
  input  logic [COUNT_W-1:0]  count,
  input  logic [COUNT_W-1:0]  alarmVal,
  input  logic [SCALE_W-1:0]  scaleVal,
  input  logic [PERIOD_W-1:0] periodVal,
  output strobe_t             stb,
  output logic [DATA_W-1:0]   rdData,
  output logic                irq,
  output logic [NUM_SRC-1:0]  status,
  output logic [NUM_SRC-1:0]  mask
);
  logic [NUM_SRC-1:0] setVec;
  logic               rdStat;
  logic               wrOn;
  logic               wrOff;
  logic               unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:NUM_SRC];

  assign stb.wrPeriod = wrEn & (addr == ADDR_W'(ADR_PERIOD));
  assign stb.wrScale  = wrEn & (addr == ADDR_W'(ADR_SCALE));
  assign stb.wrAlarm  = wrEn & (addr == ADDR_W'(ADR_ALARM));
  assign wrOn         = wrEn & (addr == ADDR_W'(ADR_IEN));
  assign wrOff        = wrEn & (addr == ADDR_W'(ADR_IDIS));
  assign rdStat       = rdEn & (addr == ADDR_W'(ADR_STATUS));

  always_comb begin
    setVec          = '0;
    setVec[ST_IV]   = evt.iv;
    setVec[ST_WDOG] = 1'b0;
    setVec[ST_INC]  = evt.inc;
    setVec[ST_ALM]  = evt.alm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~{NUM_SRC{rdStat}}) | setVec;
      if (wrOn)  mask <= mask | wrData[NUM_SRC-1:0];
      if (wrOff) mask <= mask & ~wrData[NUM_SRC-1:0];
    end
  end

  assign irq = |(status & mask);

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        ADDR_W'(ADR_PERIOD): rdData = DATA_W'(periodVal);
        ADDR_W'(ADR_SCALE):  rdData = DATA_W'(scaleVal);
        ADDR_W'(ADR_ALARM):  rdData = DATA_W'(alarmVal);
        ADDR_W'(ADR_STATUS): rdData = DATA_W'(status);
        ADDR_W'(ADR_MASK):   rdData = DATA_W'(mask);
        ADDR_W'(ADR_COUNT):  rdData = DATA_W'(count);
        default:             rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/slow_timer.sv
module slow_timer
  import slow_timer_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int COUNT_W   = 20,
  parameter int SCALE_W   = 16,
  parameter int PERIOD_W  = 16,
  parameter int SCALE_RST = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  strobe_t             stb;
  evt_t                evt;
  logic [COUNT_W-1:0]  count;
  logic [COUNT_W-1:0]  alarmVal;
  logic [SCALE_W-1:0]  scaleVal;
  logic [PERIOD_W-1:0] periodVal;
  logic [NUM_SRC-1:0]  status;
  logic [NUM_SRC-1:0]  mask;

  slow_timer_dp #(
    .DATA_W(DATA_W), .COUNT_W(COUNT_W), .SCALE_W(SCALE_W),
    .PERIOD_W(PERIOD_W), .SCALE_RST(SCALE_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb), .wrData(wrData),
    .count(count), .alarmVal(alarmVal), .scaleVal(scaleVal),
    .periodVal(periodVal), .evt(evt)
  );

  slow_timer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W),
    .SCALE_W(SCALE_W), .PERIOD_W(PERIOD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .evt(evt), .count(count), .alarmVal(alarmVal),
    .scaleVal(scaleVal), .periodVal(periodVal), .stb(stb),
    .rdData(rdData), .irq(irq), .status(status), .mask(mask)
  );
endmodule

// File: rtl/slow_timer_chk.sv
module slow_timer_chk
  import slow_timer_pkg::*;
#(
  parameter int COUNT_W = 20,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  addr,
  input logic               wrEn,
  input logic               rdEn,
  input evt_t               evt,
  input logic [COUNT_W-1:0] count,
  input logic [COUNT_W-1:0] alarmVal,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] mask
);
  logic maskWrite;
  assign maskWrite = wrEn & ((addr == ADDR_W'(ADR_IEN)) | (addr == ADDR_W'(ADR_IDIS)));

  // R3: the counter only holds or steps by one, wrapping at the top
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == COUNT_W'($past(count) + 1'b1)));

  // R4: a freshly raised alarm flag means the counter sits on the alarm value
  assert_alarm_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(status[ST_ALM]) && !$past(wrEn && (addr == ADDR_W'(ADR_ALARM))))
      |-> (count == alarmVal));

  // R6: the watchdog source never asserts
  assert_wdog_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    status[ST_WDOG] == 1'b0);

  // R7: a status read with no new event leaves nothing pending
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == ADDR_W'(ADR_STATUS)) && !evt.iv && !evt.inc && !evt.alm)
      |=> (status == '0));

  // R8: the mask only moves on an enable or disable write
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrite |=> $stable(mask));
endmodule

bind slow_timer slow_timer_chk #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .evt(evt),
  .count(count), .alarmVal(alarmVal), .status(status), .mask(mask)
);

// File: tb/tb_slow_timer.sv
module tb_slow_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 12;
  localparam int CMASK      = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // reference model state
  int mScale, mPeriod, mAlarm, mCount, mPsc, mIv, mStatus, mMask;

  slow_timer #(.COUNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int modelRead(int a);
    case (a)
      0: return mPeriod;
      1: return mScale;
      2: return mAlarm;
      3: return mStatus;
      6: return mMask;
      7: return mCount;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    mScale = 32768; mPeriod = 0; mAlarm = 0; mCount = 0;
    mPsc = 0; mIv = 0; mStatus = 0; mMask = 0;
  endtask

  task automatic modelUpdate(bit tk, bit we, int a, int d, bit re);
    bit evIv = 0, evInc = 0, evAlm = 0;
    int eff;
    if (we && a == 1) begin
      mPsc = 0; mScale = d & 16'hFFFF;
    end else if (tk) begin
      eff = (mScale == 0) ? 65536 : mScale;
      if (mPsc == eff - 1) begin mPsc = 0; evInc = 1; end
      else mPsc++;
    end
    if (we && a == 0) begin
      mIv = 0; mPeriod = d & 16'hFFFF;
    end else if (tk) begin
      eff = (mPeriod == 0) ? 65536 : mPeriod;
      if (mIv == eff - 1) begin mIv = 0; evIv = 1; end
      else mIv++;
    end
    if (evInc) begin
      mCount = (mCount + 1) & CMASK;
      if (mCount == mAlarm) evAlm = 1;
    end
    if (we && a == 2) mAlarm = d & CMASK;
    if (we && a == 4) mMask = mMask | (d & 15);
    if (we && a == 5) mMask = mMask & ~d & 15;
    if (re && a == 3) mStatus = 0;
    mStatus = mStatus | int'(evIv) | (int'(evInc) << 2) | (int'(evAlm) << 3);
  endtask

  // one clock: drive, check read data, advance model, check irq (R9)
  task automatic step(bit tk, bit we, int a, int d, bit re);
    tickEn = tk; wrEn = we; addr = a[3:0]; wrData = d; rdEn = re;
    #1;
    if (re) check(curReq, int'(rdData), modelRead(a), $sformatf("read addr %0d", a));
    @(posedge clk);
    modelUpdate(tk, we, a, d, re);
    @(negedge clk);
    check("R9", int'(irq), int'((mStatus & mMask) != 0), "irq");
    tickEn = 0; wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(int a, int d);
    step(0, 1, a, d, 0);
  endtask

  task automatic rd(int a);
    step(0, 0, a, 0, 1);
  endtask

  task automatic run(int n, int div);
    for (int i = 0; i < n; i++) step((i % div) == 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R10: reset values and map
    curReq = "R1";
    for (int a = 0; a < 8; a++) rd(a);
    check("R1", int'(irq), 0, "irq after reset");
    curReq = "R10";
    rd(9); rd(15);
    wr(2, 32'h0000_0123); rd(2);
    wr(2, 0);

    // R8: mask set / clear, zeros ignored
    curReq = "R8";
    wr(4, 32'h5); rd(6);
    wr(4, 32'h0); rd(6);
    wr(5, 32'h4); rd(6);
    wr(5, 32'h0); rd(6);
    wr(4, 32'hF); rd(6);

    // R2: default scale needs 32768 ticks per increment
    curReq = "R2";
    run(32767, 1); rd(7);
    run(2, 1); rd(7);
    wr(1, 3);
    run(20, 2); rd(7);
    // tick coinciding with a scale write is not counted
    step(1, 1, 1, 1, 0);
    run(5, 1); rd(7);

    // R6: increment status with scale 1
    curReq = "R6";
    rd(3);
    step(1, 0, 0, 0, 0);
    rd(3); rd(3);
    check("R6", int'(irq), 0, "irq after clear");

    // R4: alarm a few increments ahead
    curReq = "R4";
    wr(2, (mCount + 5) & CMASK);
    run(4, 1); rd(3);
    run(1, 1); rd(3);
    // alarm armed at current value: silent for a whole wrap
    wr(2, mCount);
    run(4095, 1); rd(3);
    curReq = "R3";
    rd(7);
    curReq = "R4";
    run(1, 1); rd(3); rd(7);

    // R5: interval with sparse ticks and restart on write
    curReq = "R5";
    wr(0, 7);
    run(13, 2); rd(3);
    run(2, 2); rd(3);
    run(6, 1);
    wr(0, 7);
    run(6, 1); rd(3);
    run(1, 1); rd(3);

    // R7: status read on every cycle while events arrive
    curReq = "R7";
    for (int i = 0; i < 40; i++) step(1, 0, 3, 0, 1);
    rd(3); rd(3);

    // R2 / R5: zero scale and zero period mean 65536 ticks
    curReq = "R5";
    wr(0, 0);
    curReq = "R2";
    wr(1, 0);
    rd(3);
    run(65535, 1); rd(3); rd(7);
    run(1, 1); rd(3); rd(7);

    // R9: disabling all sources drops irq
    curReq = "R9";
    run(3, 1);
    wr(5, 32'hF); rd(6);
    check("R9", int'(irq), 0, "irq with empty mask");

    finishRun();
  end
endmodule